// File: doc/BRIEF.md
# Timer with Compare-Clear Output

This block is an 8-bit up-counter for general event timing. A free-running prescaler produces a one-cycle count enable. Software selects the prescaler rate, the compare value and what happens when the count reaches that value. On a match, the block can restart the count from zero. It can also drive a single output line in one of three ways, or leave it alone. Every match raises a sticky flag, which can interrupt the host.

The host reaches four 8-bit registers through a simple synchronous write port and a registered read port:

| Address | Register |
|---|---|
| 0 | control |
| 1 | live count |
| 2 | compare value |
| 3 | status |

The output line reaches the pin only while the direction-enable input is high. A control bit intended for a pulse-width mode is stored and read back. Setting it has one effect here: it freezes the counter and suppresses every match action.

Top module: `cmp_timer`

## Requirements
- R1: After a synchronous reset, all four registers read 0, the compare pin is 0 and the interrupt is 0. No match is reported in the first cycles after reset, even though count and compare are both 0.
- R2: Control register layout:
  - bits 2:0: clock select
  - bit 3: clear-on-match
  - bits 5:4: pin mode
  - bit 6: freeze bit
  - bit 7: always reads 0; writes to it are ignored. Writing 0xFF reads back 0x7F.
- R3: On each match, the pin mode acts on the output flip-flop:
  - 01 inverts it
  - 10 forces it to 0
  - 11 forces it to 1
  - 00 leaves it unchanged

  Between matches the flip-flop holds its value.
- R4: With clear-on-match set, the counter becomes 0 at the clock edge after the cycle in which it first equals the compare value. At prescale 1 and compare value C, the sequence is C-2, C-1, C, 0, 1, with C present for one cycle. With clear-on-match off, the counter passes C and wraps at 255 to 0.
- R5: With prescale above 1 and clear-on-match set, the clear still lands one cycle after the count reaches C, before the next count enable. At divide-by-8 with C=2, the value 2 lasts one cycle per 16-cycle period and is followed by 0.
- R6: Clock select picks the count rate:
  - 0 stops the counter
  - 1 through 7 advance it once every 1, 8, 32, 64, 128, 256 and 1024 clocks respectively
- R7: The compare pin equals the output flip-flop while the direction enable is 1, and is 0 while it is 0.
- R8: While the freeze bit (control bit 6) is 1, the counter does not advance and no match has any effect: no flag, no pin action and no clear.
- R9: A match sets the status flag (status bit 0), which stays set until a write to status with bit 0 equal to 1. Writing 0 to bit 0 leaves it set. A match in the same cycle as a clearing write leaves the flag set.
- R10: Status bit 1 is the interrupt mask, freely written. The interrupt output is 1 exactly while flag and mask are both 1.
- R11: A write to the count register takes priority over the clear and the count enable in its cycle. It also suppresses any match in the following cycle, so loading the compare value itself raises no flag and causes no clear.
- R12: A match is reported once per arrival at the compare value. It fires when the count becomes equal, or when a compare write makes it equal, not on every cycle that equality holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 control, 1 count, 2 compare, 3 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register selected in the previous cycle |
| dir_en | input | 1 | Direction enable gating the compare pin |
| cmp_pin | output | 1 | Compare output pin |
| irq | output | 1 | Match interrupt, flag AND mask |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a count-register write and a clear-on-match. The bench stops the counter, loads a count, and then writes a compare value equal to that count. It follows at once with a count write of a different value. The match from the compare write is then evaluated on the same edge as the second write. The count must show the written value, while the flag and the pin still respond to the match.

The second pair is a match and a flag-clearing status write. These are provoked the same way, and the flag must remain set. Control runs without the collision confirm that the clear and the flag clear do work on their own.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  // Pin action applied on each compare match
  typedef enum logic [1:0] {
    PIN_OFF    = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_mode_e;

  // Control register layout, bit 7 down to bit 0
  typedef struct packed {
    logic      rsvd;
    logic      freeze;
    pin_mode_e mode;
    logic      clr_on_match;
    logic [2:0] clk_sel;
  } ctrl_t;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_CMP   = 2'd2;
  localparam logic [1:0] A_STAT  = 2'd3;

  localparam int SEL_W   = 3;
  localparam int SEL_N   = 1 << SEL_W;
  localparam int CTRL_W  = $bits(ctrl_t);

  // log2 of the division ratio for each clock-select code
  function automatic int div_shift(input int sel);
    case (sel)
      1:       return 0;
      2:       return 3;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      6:       return 8;
      7:       return 10;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler
  import cmp_timer_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic [SEL_N-1:0] sel_tick;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // Code 0 never ticks: the counter stands still
  assign sel_tick[0] = 1'b0;

  // One enable per divider, all taken from the same free-running counter
  generate
    for (genvar g = 1; g < SEL_N; g++) begin : g_div
      localparam int SH = div_shift(g);
      localparam logic [PRE_W-1:0] LOW_MASK = PRE_W'((1 << SH) - 1);
      assign sel_tick[g] = ((pre_q & LOW_MASK) == LOW_MASK);
    end
  endgenerate

  assign tick = sel_tick[sel];

endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic             clr_en,
  input  logic             freeze,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             match
);

  logic [CNT_W-1:0] cnt_q;
  logic             eq;
  logic             eq_q;
  logic             ld_q;

  assign eq    = (cnt_q == cmp_val);
  // Report only the arrival at equality; a load blocks the next cycle
  assign match = eq & ~eq_q & ~ld_q & ~freeze;
  assign cnt   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      eq_q  <= 1'b1;   // count and compare both reset to 0: no match
      ld_q  <= 1'b0;
    end else begin
      eq_q <= eq;
      ld_q <= ld;
      if (ld)
        cnt_q <= ld_val;
      else if (match && clr_en)
        cnt_q <= '0;
      else if (adv && !freeze)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  p_clear_after_match_r4: assert property (@(posedge clk) disable iff (rst)
    (match && clr_en && !ld) |=> (cnt_q == '0));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(ld_val)));

  p_load_blocks_match_r11: assert property (@(posedge clk) disable iff (rst)
    ld |=> !match);

  p_freeze_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ld) |=> $stable(cnt_q));

  p_single_report_r12: assert property (@(posedge clk) disable iff (rst)
    (match && $stable(cmp_val)) |=> !match);

endmodule

// File: rtl/cmp_timer_outctl.sv
module cmp_timer_outctl
  import cmp_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      match,
  input  pin_mode_e mode,
  input  logic      dir_en,
  input  logic      flag_clr,
  input  logic      mask_wr,
  input  logic      mask_val,
  output logic      pin,
  output logic      flag,
  output logic      mask,
  output logic      irq
);

  logic oc_q;
  logic flag_q, flag_d;
  logic mask_q, mask_d;
  logic irq_q;

  // Compare output flip-flop
  always_ff @(posedge clk) begin
    if (rst) begin
      oc_q <= 1'b0;
    end else if (match) begin
      case (mode)
        PIN_TOGGLE: oc_q <= ~oc_q;
        PIN_LOW:    oc_q <= 1'b0;
        PIN_HIGH:   oc_q <= 1'b1;
        default:    oc_q <= oc_q;
      endcase
    end
  end

  // Sticky flag: a match beats a clearing write in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (match)         flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
    mask_d = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq_q  <= flag_d & mask_d;
    end
  end

  assign pin  = oc_q & dir_en;
  assign flag = flag_q;
  assign mask = mask_q;
  assign irq  = irq_q;

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst)
    (match && mode == PIN_TOGGLE) |=> (oc_q != $past(oc_q)));

  p_drive_high_r3: assert property (@(posedge clk) disable iff (rst)
    (match && mode == PIN_HIGH) |=> oc_q);

  p_drive_low_r3: assert property (@(posedge clk) disable iff (rst)
    (match && mode == PIN_LOW) |=> !oc_q);

  p_hold_between_r3: assert property (@(posedge clk) disable iff (rst)
    (!match || mode == PIN_OFF) |=> $stable(oc_q));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    match |=> flag_q);

  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_q && mask_q && !flag_clr && !mask_wr) |=> irq_q);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             dir_en,
  output logic             cmp_pin,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] rdata_q;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             match;
  logic             cnt_ld;
  logic             flag_clr;
  logic             mask_wr;
  logic             flag;
  logic             mask;

  assign cnt_ld   = wr_en && (addr == A_COUNT);
  assign mask_wr  = wr_en && (addr == A_STAT);
  assign flag_clr = mask_wr && wdata[0];

  // Control and compare registers; bit 7 of control is forced to 0
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= ctrl_t'({1'b0, wdata[CTRL_W-2:0]});
      if (addr == A_CMP)  cmp_q  <= wdata;
    end
  end

  cmp_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .sel  (ctrl_q.clk_sel),
    .tick (tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (tick),
    .clr_en  (ctrl_q.clr_on_match),
    .freeze  (ctrl_q.freeze),
    .cmp_val (cmp_q),
    .ld      (cnt_ld),
    .ld_val  (wdata),
    .cnt     (cnt),
    .match   (match)
  );

  cmp_timer_outctl u_out (
    .clk      (clk),
    .rst      (rst),
    .match    (match),
    .mode     (ctrl_q.mode),
    .dir_en   (dir_en),
    .flag_clr (flag_clr),
    .mask_wr  (mask_wr),
    .mask_val (wdata[1]),
    .pin      (cmp_pin),
    .flag     (flag),
    .mask     (mask),
    .irq      (irq)
  );

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (addr)
        A_CTRL:  rdata_q <= CNT_W'(ctrl_q);
        A_COUNT: rdata_q <= cnt;
        A_CMP:   rdata_q <= cmp_q;
        default: rdata_q <= CNT_W'({mask, flag});
      endcase
    end
  end

  assign rdata = rdata_q;

  p_stopped_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.clk_sel == '0 && !cnt_ld && !(match && ctrl_q.clr_on_match))
      |=> $stable(cnt));

  p_freeze_no_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.freeze && !flag) |=> !flag);

endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_CNT  = 2'd1;
  localparam logic [1:0] RA_CMP  = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       dir_en = 1'b1;
  logic       cmp_pin;
  logic       irq;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  cmp_timer uut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .dir_en  (dir_en),
    .cmp_pin (cmp_pin),
    .irq     (irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Two writes on consecutive clock edges
  task automatic do_wr2(input logic [1:0] a1, input logic [7:0] d1,
                        input logic [1:0] a2, input logic [7:0] d2);
    @(negedge clk);
    addr = a1; wdata = d1; wr_en = 1'b1;
    @(negedge clk);
    addr = a2; wdata = d2;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    #1 v = rdata;
  endtask

  task automatic t_reset();
    int v;
    do_rd(RA_CTRL, v); chk("R1 ctrl", v, 0);
    do_rd(RA_CNT, v);  chk("R1 count", v, 0);
    do_rd(RA_CMP, v);  chk("R1 compare", v, 0);
    do_rd(RA_STAT, v); chk("R1 status", v, 0);
    chk("R1 pin", int'(cmp_pin), 0);
    chk("R1 irq", int'(irq), 0);
  endtask

  task automatic t_reserved();
    int v;
    do_wr(RA_CTRL, 8'hFF);
    do_rd(RA_CTRL, v); chk("R2 reserved bit", v, 8'h7F);
    do_wr(RA_CTRL, 8'h00);
  endtask

  // Sample the count on consecutive cycles and test a recurrence
  task automatic t_ctc_p1();
    int s[20];
    int bad = 0;
    int cs = 0;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CMP, 8'd5);
    do_wr(RA_CNT, 8'd0);
    do_wr(RA_CTRL, 8'h09);
    @(negedge clk); addr = RA_CNT;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 s[i] = rdata;
    end
    for (int i = 0; i < 19; i++) begin
      if (s[i+1] != ((s[i] == 5) ? 0 : s[i] + 1)) bad++;
      if (s[i] == 5) cs++;
    end
    chk("R4 clear sequence C-1,C,0", bad, 0);
    chk("R4 compare value seen", int'(cs >= 3), 1);
  endtask

  task automatic t_no_ctc();
    int s[20];
    int bad = 0;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CMP, 8'd5);
    do_wr(RA_CNT, 8'd250);
    do_wr(RA_CTRL, 8'h01);
    @(negedge clk); addr = RA_CNT;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1 s[i] = rdata;
    end
    for (int i = 0; i < 19; i++)
      if (s[i+1] != ((s[i] + 1) % 256)) bad++;
    chk("R4 no clear, wraps and passes C", bad, 0);
    do_wr(RA_STAT, 8'h01);
  endtask

  task automatic t_ctc_div8();
    int s[64];
    int bad = 0;
    int twos = 0;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CMP, 8'd2);
    do_wr(RA_CNT, 8'd0);
    do_wr(RA_CTRL, 8'h0A);
    @(negedge clk); addr = RA_CNT;
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1 s[i] = rdata;
    end
    for (int i = 1; i < 63; i++) begin
      if (s[i] == 2) begin
        twos++;
        if (s[i+1] != 0 || s[i-1] != 1) bad++;
      end
    end
    chk("R5 C held one cycle then 0", bad, 0);
    chk("R5 arrivals per 64 cycles", int'(twos >= 3 && twos <= 4), 1);
  endtask

  task automatic t_prescale();
    int cs_w[8] = '{64, 64, 64, 64, 128, 256, 512, 2048};
    int cs_e[8] = '{0, 64, 8, 2, 2, 2, 2, 2};
    int a, b;
    for (int c = 0; c < 8; c++) begin
      do_wr(RA_CTRL, 8'h00);
      do_wr(RA_CMP, 8'd255);
      do_wr(RA_CNT, 8'd0);
      do_wr(RA_CTRL, 8'(c));
      @(negedge clk); addr = RA_CNT;
      @(posedge clk); #1 a = rdata;
      repeat (cs_w[c]) @(posedge clk);
      #1 b = rdata;
      chk($sformatf("R6 clock select %0d advance", c), (b - a + 256) % 256, cs_e[c]);
    end
    do_wr(RA_CTRL, 8'h00);
  endtask

  task automatic t_pin_modes();
    int tr;
    logic prev;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CMP, 8'd3);
    do_wr(RA_CNT, 8'd0);
    do_wr(RA_CTRL, 8'h19);
    repeat (8) @(posedge clk);
    #1 prev = cmp_pin; tr = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (cmp_pin != prev) tr++;
      prev = cmp_pin;
    end
    chk("R3 toggle mode transitions", tr, 10);
    do_wr(RA_CTRL, 8'h09);
    repeat (2) @(posedge clk);
    #1 prev = cmp_pin; tr = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (cmp_pin != prev) tr++;
      prev = cmp_pin;
    end
    chk("R3 mode 00 leaves pin", tr, 0);
    do_wr(RA_CTRL, 8'h39);
    repeat (10) @(posedge clk); #1;
    chk("R3 mode 11 sets pin", int'(cmp_pin), 1);
    do_wr(RA_CTRL, 8'h29);
    repeat (10) @(posedge clk); #1;
    chk("R3 mode 10 clears pin", int'(cmp_pin), 0);
    do_wr(RA_CTRL, 8'h39);
    repeat (10) @(posedge clk);
    do_wr(RA_CTRL, 8'h00);
    @(negedge clk); dir_en = 1'b0; #1;
    chk("R7 pin gated off", int'(cmp_pin), 0);
    @(negedge clk); dir_en = 1'b1; #1;
    chk("R7 pin passes flip-flop", int'(cmp_pin), 1);
    do_wr(RA_STAT, 8'h01);
  endtask

  task automatic t_freeze();
    int a, b, f;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CNT, 8'd10);
    do_wr(RA_CMP, 8'd12);
    do_wr(RA_STAT, 8'h01);
    do_wr(RA_CTRL, 8'h59);
    do_rd(RA_CNT, a);
    repeat (20) @(posedge clk);
    do_rd(RA_CNT, b);
    chk("R8 frozen counter", b, a);
    chk("R8 frozen count value", a, 10);
    do_wr(RA_CMP, 8'd10);
    repeat (3) @(posedge clk);
    do_rd(RA_CNT, a);
    chk("R8 no clear while frozen", a, 10);
    do_rd(RA_STAT, f);
    chk("R8 no flag while frozen", f & 1, 0);
    chk("R8 pin untouched while frozen", int'(cmp_pin), 1);
    do_wr(RA_CTRL, 8'h00);
  endtask

  task automatic t_flag_irq();
    int v;
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CNT, 8'd7);
    do_wr(RA_CMP, 8'd6);
    do_wr(RA_STAT, 8'h01);
    do_wr(RA_CMP, 8'd7);
    do_rd(RA_STAT, v);
    chk("R9 match sets flag", v, 1);
    chk("R10 masked irq", int'(irq), 0);
    do_wr(RA_STAT, 8'h02);
    do_rd(RA_STAT, v);
    chk("R9 writing 0 keeps flag", v, 3);
    chk("R10 irq with mask", int'(irq), 1);
    do_wr(RA_STAT, 8'h03);
    do_rd(RA_STAT, v);
    chk("R9 write 1 clears flag", v, 2);
    chk("R10 irq drops", int'(irq), 0);
    do_wr(RA_STAT, 8'h01);
  endtask

  task automatic t_collisions();
    int v;
    do_wr(RA_CTRL, 8'h38);
    do_wr(RA_CNT, 8'd50);
    do_wr(RA_CMP, 8'd49);
    do_wr(RA_STAT, 8'h01);
    do_wr(RA_CTRL, 8'h28);
    do_wr(RA_CTRL, 8'h38);
    do_wr2(RA_CMP, 8'd50, RA_CNT, 8'd77);
    do_rd(RA_CNT, v);
    chk("R11 load beats clear", v, 77);
    do_rd(RA_STAT, v);
    chk("R11 match still flagged", v & 1, 1);
    chk("R11 match still drives pin", int'(cmp_pin), 1);
    // Control run: same compare write alone must clear
    do_wr(RA_CMP, 8'd49);
    do_wr(RA_CNT, 8'd50);
    do_wr(RA_CMP, 8'd50);
    do_rd(RA_CNT, v);
    chk("R4 compare write causes clear", v, 0);
    // Match and flag clear on the same edge
    do_wr(RA_CTRL, 8'h00);
    do_wr(RA_CNT, 8'd30);
    do_wr(RA_CMP, 8'd29);
    do_wr(RA_STAT, 8'h01);
    do_wr2(RA_CMP, 8'd30, RA_STAT, 8'h01);
    do_rd(RA_STAT, v);
    chk("R9 set wins over clear", v & 1, 1);
    do_wr(RA_STAT, 8'h01);
    do_rd(RA_STAT, v);
    chk("R9 later clear works", v & 1, 0);
    // Loading the compare value itself: no match
    do_wr(RA_CTRL, 8'h08);
    do_wr(RA_CMP, 8'd60);
    do_wr(RA_CNT, 8'd60);
    repeat (3) @(posedge clk);
    do_rd(RA_CNT, v);
    chk("R11 loaded C not cleared", v, 60);
    do_rd(RA_STAT, v);
    chk("R12 no flag after load of C", v & 1, 0);
    // Load while counting with clear enabled
    do_wr(RA_CMP, 8'd20);
    do_wr(RA_CTRL, 8'h09);
    do_wr(RA_CNT, 8'd20);
    do_rd(RA_CNT, v);
    chk("R11 load blocks next match", v, 21);
    do_wr(RA_CTRL, 8'h00);
  endtask

  initial begin
    #(10 * 100000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_reserved();
    t_ctc_p1();
    t_no_ctc();
    t_ctc_div8();
    t_prescale();
    t_pin_modes();
    t_freeze();
    t_flag_irq();
    t_collisions();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule